// File: doc/BRIEF.md
# Accumulator ALU with Skip Flags

This block is the execute stage of a small accumulator-style processor. It applies one operation to the accumulator value and a second operand, taken from memory or from an immediate field. The carry flag enters as an input. The block returns the result, the new carry and zero flags, a write-back enable and a flag that tells the sequencer to skip the next instruction. Everything except one register is combinational, so a result is ready in the same cycle the operation code is presented.

The operations are:
- add, subtract and reverse subtract, each with optional carry or borrow;
- carry-only add and subtract;
- AND, OR, XOR, complement and negate;
- plain and through-carry shifts, and a nibble swap;
- two compares;
- increment and decrement, with forms that skip on a zero result;
- an unsigned multiply.

The multiply returns the low byte of the product as its result. It keeps the high byte in a register that software can only read, and that register loads at the clock edge that ends the multiply cycle. Write-back to the register file and instruction fetch belong to the surrounding core.

Top module: `acc_alu_core`

## Requirements
- R1: Op 0 (add) gives acc+opnd, op 1 (add with carry) gives acc+opnd+carry_i, and op 2 (carry-only add) gives acc+carry_i. Each of these sets carry_o to the carry out of the top bit and sets wb_o.
- R2: Op 3 (subtract) gives acc-opnd, op 4 (subtract with borrow) gives acc-opnd-carry_i, and op 5 (carry-only subtract) gives acc-carry_i. Each sets carry_o to 1 when a borrow occurred and sets wb_o.
- R3: Op 6 (reverse subtract) gives opnd-acc, which is the operand plus the two's complement of acc. carry_o is the borrow of that subtraction.
- R4: Ops 7 (AND), 8 (OR), 9 (XOR) and 10 (complement of acc) give the bitwise result, set wb_o and leave carry_o equal to carry_i.
- R5: Op 11 (negate) gives the two's complement of acc and leaves carry_o equal to carry_i.
- R6: Op 12 (shift left) and op 13 (shift right) act on acc. The vacated bit is filled with 0 and the bit shifted out goes to carry_o.
- R7: Op 14 (rotate left through carry) and op 15 (rotate right through carry) act on acc. The vacated bit is filled from carry_i and the bit shifted out goes to carry_o.
- R8: Op 16 swaps the upper and lower halves of acc and leaves carry_o equal to carry_i.
- R9: Ops 17 (compare) and 18 (compare and skip) set carry_o and zero_o as acc-opnd would and hold wb_o low. Only op 18 raises skip_o, and it does so exactly when acc equals opnd.
- R10: Op 19 (increment) gives acc+1 and op 20 (decrement) gives acc-1. Op 21 (increment and skip) and op 22 (decrement and skip) give the same results and raise skip_o when the result is zero. All four set wb_o and leave carry_o equal to carry_i. No other op raises skip_o.
- R11: Op 23 (multiply) gives the low half of the unsigned product acc*opnd on res_o and leaves carry_o equal to carry_i. The high half appears on mul_hi_o after the next rising clock edge. mul_hi_o is 0 after reset and holds its value while any other op is presented.
- R12: zero_o is 1 exactly when res_o is zero, for every op code.
- R13: Any op code of 24 or above passes acc to res_o, leaves carry_o equal to carry_i, and holds wb_o and skip_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the high-product register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| acc_i | input | DATA_W | Accumulator operand |
| opnd_i | input | DATA_W | Memory or immediate operand |
| carry_i | input | 1 | Current carry flag |
| res_o | output | DATA_W | Operation result |
| carry_o | output | 1 | Updated carry flag |
| zero_o | output | 1 | Result-is-zero flag |
| skip_o | output | 1 | Skip the next instruction |
| wb_o | output | 1 | Result should be written back |
| mul_hi_o | output | DATA_W | High half of the last product |

## Verification
Two things happen in the cycle right after a multiply. The registered high product becomes visible, and the combinational path is already computing a different operation. The bench presents a multiply, lets one clock edge pass, and then applies an add. It requires res_o to show the sum while mul_hi_o shows the previous product's high byte. The bench then runs a second multiply whose low byte is zero. That multiply must raise zero_o at once and must move the new high byte into the register only after its own edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int unsigned OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD    = 5'd0,
      OP_ADDC   = 5'd1,
      OP_ADDCY  = 5'd2,
      OP_SUB    = 5'd3,
      OP_SUBC   = 5'd4,
      OP_SUBCY  = 5'd5,
      OP_RSUB   = 5'd6,
      OP_AND    = 5'd7,
      OP_OR     = 5'd8,
      OP_XOR    = 5'd9,
      OP_NOT    = 5'd10,
      OP_NEG    = 5'd11,
      OP_SHL    = 5'd12,
      OP_SHR    = 5'd13,
      OP_RCL    = 5'd14,
      OP_RCR    = 5'd15,
      OP_SWAP   = 5'd16,
      OP_CMP    = 5'd17,
      OP_CEQ    = 5'd18,
      OP_INC    = 5'd19,
      OP_DEC    = 5'd20,
      OP_INCSZ  = 5'd21,
      OP_DECSZ  = 5'd22,
      OP_MUL    = 5'd23
   } alu_op_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] r_o,
   output logic         cbo_o
);

   logic [W:0] wide;

   always_comb begin
      if (sub_i)
         wide = {1'b0, x_i} - {1'b0, y_i} - {{W{1'b0}}, cin_i};
      else
         wide = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
      r_o   = wide[W-1:0];
      cbo_o = wide[W];
   end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] v_i,
   input  logic         cin_i,
   input  logic         left_i,
   input  logic         rot_i,
   output logic [W-1:0] r_o,
   output logic         cout_o,
   output logic [W-1:0] swp_o
);

   localparam int unsigned H = W / 2;

   logic fill;

   always_comb begin
      fill = rot_i ? cin_i : 1'b0;
      if (left_i) begin
         r_o    = {v_i[W-2:0], fill};
         cout_o = v_i[W-1];
      end else begin
         r_o    = {fill, v_i[W-1:1]};
         cout_o = v_i[0];
      end
      swp_o = {v_i[H-1:0], v_i[W-1:H]};
   end

endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
   parameter int unsigned W         = 8,
   parameter bit          SHIFT_ADD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cap_i,
   output logic [W-1:0] lo_o,
   output logic [W-1:0] hi_q_o
);

   localparam int unsigned PW = 2 * W;

   logic [PW-1:0] prod;

   generate
      if (SHIFT_ADD) begin : g_shift_add
         always_comb begin
            prod = '0;
            for (int i = 0; i < W; i++) begin
               if (b_i[i])
                  prod = prod + ({{W{1'b0}}, a_i} << i);
            end
         end
      end else begin : g_direct
         assign prod = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
      end
   endgenerate

   assign lo_o = prod[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_q_o <= '0;
      else if (cap_i)
         hi_q_o <= prod[PW-1:W];
   end

   // R11: the high register holds unless the previous cycle was a multiply
   p_hi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cap_i) |-> $stable(hi_q_o));

   // R11: after a multiply the register carries that product's high half
   p_hi_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cap_i) && $past(rst_n)) |-> (hi_q_o == $past(prod[PW-1:W])));

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter bit          MUL_SHIFT_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] res_o,
   output logic              carry_o,
   output logic              zero_o,
   output logic              skip_o,
   output logic              wb_o,
   output logic [DATA_W-1:0] mul_hi_o
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (DATA_W < 4) begin : g_chk_width
         $error("acc_alu_core: DATA_W must be at least 4");
      end
      if ((HALF_W * 2) != DATA_W) begin : g_chk_even
         $error("acc_alu_core: DATA_W must be even for the half swap");
      end
   endgenerate

   logic [DATA_W-1:0] as_x, as_y, as_r;
   logic              as_cin, as_sub, as_cbo;
   logic [DATA_W-1:0] sh_r, swp_r, mul_lo;
   logic              sh_left, sh_rot, sh_cout, mul_cap;

   // operand steering for the shared adder/subtractor
   always_comb begin
      as_x   = acc_i;
      as_y   = opnd_i;
      as_cin = 1'b0;
      as_sub = 1'b0;
      case (op_i)
         OP_ADDC:            as_cin = carry_i;
         OP_ADDCY:           begin as_y = '0; as_cin = carry_i; end
         OP_SUB, OP_CMP,
         OP_CEQ:             as_sub = 1'b1;
         OP_SUBC:            begin as_sub = 1'b1; as_cin = carry_i; end
         OP_SUBCY:           begin as_y = '0; as_sub = 1'b1; as_cin = carry_i; end
         OP_RSUB:            begin as_x = opnd_i; as_y = acc_i; as_sub = 1'b1; end
         OP_NEG:             begin as_x = '0; as_y = acc_i; as_sub = 1'b1; end
         OP_INC, OP_INCSZ:   as_y = ONE;
         OP_DEC, OP_DECSZ:   begin as_y = ONE; as_sub = 1'b1; end
         default:            ;
      endcase
   end

   assign sh_left = (op_i == OP_SHL) || (op_i == OP_RCL);
   assign sh_rot  = (op_i == OP_RCL) || (op_i == OP_RCR);
   assign mul_cap = (op_i == OP_MUL);

   acc_alu_addsub #(.W(DATA_W)) u_addsub (
      .x_i   (as_x),
      .y_i   (as_y),
      .cin_i (as_cin),
      .sub_i (as_sub),
      .r_o   (as_r),
      .cbo_o (as_cbo)
   );

   acc_alu_shift #(.W(DATA_W)) u_shift (
      .v_i    (acc_i),
      .cin_i  (carry_i),
      .left_i (sh_left),
      .rot_i  (sh_rot),
      .r_o    (sh_r),
      .cout_o (sh_cout),
      .swp_o  (swp_r)
   );

   acc_alu_mul #(.W(DATA_W), .SHIFT_ADD(MUL_SHIFT_ADD)) u_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_i    (acc_i),
      .b_i    (opnd_i),
      .cap_i  (mul_cap),
      .lo_o   (mul_lo),
      .hi_q_o (mul_hi_o)
   );

   // result, flag and control selection
   always_comb begin
      res_o   = acc_i;
      carry_o = carry_i;
      skip_o  = 1'b0;
      wb_o    = 1'b0;
      case (op_i)
         OP_ADD, OP_ADDC, OP_ADDCY, OP_SUB, OP_SUBC, OP_SUBCY, OP_RSUB: begin
            res_o = as_r; carry_o = as_cbo; wb_o = 1'b1;
         end
         OP_AND:  begin res_o = acc_i & opnd_i; wb_o = 1'b1; end
         OP_OR:   begin res_o = acc_i | opnd_i; wb_o = 1'b1; end
         OP_XOR:  begin res_o = acc_i ^ opnd_i; wb_o = 1'b1; end
         OP_NOT:  begin res_o = ~acc_i;         wb_o = 1'b1; end
         OP_NEG:  begin res_o = as_r;           wb_o = 1'b1; end
         OP_SHL, OP_SHR, OP_RCL, OP_RCR: begin
            res_o = sh_r; carry_o = sh_cout; wb_o = 1'b1;
         end
         OP_SWAP: begin res_o = swp_r; wb_o = 1'b1; end
         OP_CMP:  begin res_o = as_r; carry_o = as_cbo; end
         OP_CEQ:  begin res_o = as_r; carry_o = as_cbo; skip_o = (as_r == '0); end
         OP_INC, OP_DEC: begin res_o = as_r; wb_o = 1'b1; end
         OP_INCSZ, OP_DECSZ: begin
            res_o = as_r; wb_o = 1'b1; skip_o = (as_r == '0);
         end
         OP_MUL:  begin res_o = mul_lo; wb_o = 1'b1; end
         default: ;
      endcase
      zero_o = (res_o == '0);
   end

   // R10: skip comes only from compare-and-skip or the skip forms of inc/dec
   p_skip_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> (op_i == OP_CEQ || op_i == OP_INCSZ || op_i == OP_DECSZ));

   // R9: compares never request write-back
   p_cmp_nowb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CMP || op_i == OP_CEQ) |-> !wb_o);

   // R4: bitwise ops leave the carry alone
   p_logic_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_NOT)
      |-> (carry_o == carry_i));

   // R10: inc/dec skip forms skip exactly when the written value is zero
   p_skip_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_INCSZ || op_i == OP_DECSZ) |-> (skip_o == zero_o));

   // R13: unknown op codes neither write nor skip
   p_undef_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > OP_MUL) |-> (!wb_o && !skip_o && res_o == acc_i));

endmodule

// File: tb/acc_alu_core_tb.sv
module acc_alu_core_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_i = 5'd31;
   logic [7:0] acc_i = '0;
   logic [7:0] opnd_i = '0;
   logic       carry_i = 1'b0;
   logic [7:0] res_o, mul_hi_o;
   logic       carry_o, zero_o, skip_o, wb_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   acc_alu_core #(.DATA_W(8)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op_i),
      .acc_i    (acc_i),
      .opnd_i   (opnd_i),
      .carry_i  (carry_i),
      .res_o    (res_o),
      .carry_o  (carry_o),
      .zero_o   (zero_o),
      .skip_o   (skip_o),
      .wb_o     (wb_o),
      .mul_hi_o (mul_hi_o)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic apply(logic [4:0] op, logic [7:0] a, logic [7:0] b, logic c);
      @(negedge clk);
      op_i = op; acc_i = a; opnd_i = b; carry_i = c;
      #1;
   endtask

   // packed as {wb, skip, zero, carry, res}
   task automatic expect_out(string tag, logic [7:0] r, logic c, logic z, logic s, logic w);
      chk(tag, {20'd0, wb_o, skip_o, zero_o, carry_o, res_o}, {20'd0, w, s, z, c, r});
   endtask

   task automatic t_reset;
      chk("R11 reset value of mul_hi", {24'd0, mul_hi_o}, 32'd0);
   endtask

   task automatic t_add;
      apply(5'd0, 8'h3C, 8'h44, 1'b1); expect_out("R1 add", 8'h80, 0, 0, 0, 1);
      apply(5'd0, 8'hFF, 8'h01, 1'b0); expect_out("R1 add wrap", 8'h00, 1, 1, 0, 1);
      apply(5'd1, 8'h10, 8'h20, 1'b1); expect_out("R1 addc", 8'h31, 0, 0, 0, 1);
      apply(5'd2, 8'hFF, 8'h77, 1'b1); expect_out("R1 carry-only add", 8'h00, 1, 1, 0, 1);
      apply(5'd2, 8'h05, 8'h77, 1'b0); expect_out("R1 carry-only add c0", 8'h05, 0, 0, 0, 1);
   endtask

   task automatic t_sub;
      apply(5'd3, 8'h50, 8'h20, 1'b1); expect_out("R2 sub", 8'h30, 0, 0, 0, 1);
      apply(5'd3, 8'h20, 8'h50, 1'b0); expect_out("R2 sub borrow", 8'hD0, 1, 0, 0, 1);
      apply(5'd4, 8'h20, 8'h20, 1'b1); expect_out("R2 subc", 8'hFF, 1, 0, 0, 1);
      apply(5'd5, 8'h00, 8'h33, 1'b1); expect_out("R2 carry-only sub", 8'hFF, 1, 0, 0, 1);
      apply(5'd5, 8'h01, 8'h33, 1'b1); expect_out("R2 carry-only sub zero", 8'h00, 0, 1, 0, 1);
   endtask

   task automatic t_rsub;
      apply(5'd6, 8'h10, 8'h30, 1'b1); expect_out("R3 reverse sub", 8'h20, 0, 0, 0, 1);
      apply(5'd6, 8'h30, 8'h10, 1'b0); expect_out("R3 reverse sub borrow", 8'hE0, 1, 0, 0, 1);
   endtask

   task automatic t_logic;
      apply(5'd7, 8'hF0, 8'h3C, 1'b1); expect_out("R4 and", 8'h30, 1, 0, 0, 1);
      apply(5'd8, 8'h0F, 8'hF0, 1'b0); expect_out("R4 or", 8'hFF, 0, 0, 0, 1);
      apply(5'd9, 8'hAA, 8'hAA, 1'b1); expect_out("R4 xor zero R12", 8'h00, 1, 1, 0, 1);
      apply(5'd10, 8'hFF, 8'h00, 1'b0); expect_out("R4 not", 8'h00, 0, 1, 0, 1);
   endtask

   task automatic t_neg;
      apply(5'd11, 8'h01, 8'h00, 1'b1); expect_out("R5 neg", 8'hFF, 1, 0, 0, 1);
      apply(5'd11, 8'h00, 8'h00, 1'b0); expect_out("R5 neg zero", 8'h00, 0, 1, 0, 1);
      apply(5'd11, 8'h80, 8'h00, 1'b0); expect_out("R5 neg min", 8'h80, 0, 0, 0, 1);
   endtask

   task automatic t_shift;
      apply(5'd12, 8'h81, 8'h00, 1'b0); expect_out("R6 shl", 8'h02, 1, 0, 0, 1);
      apply(5'd13, 8'h81, 8'h00, 1'b1); expect_out("R6 shr zero fill", 8'h40, 1, 0, 0, 1);
      apply(5'd12, 8'h40, 8'h00, 1'b1); expect_out("R6 shl zero fill", 8'h80, 0, 0, 0, 1);
   endtask

   task automatic t_rot;
      apply(5'd14, 8'h80, 8'h00, 1'b1); expect_out("R7 rcl c1", 8'h01, 1, 0, 0, 1);
      apply(5'd14, 8'h80, 8'h00, 1'b0); expect_out("R7 rcl c0", 8'h00, 1, 1, 0, 1);
      apply(5'd15, 8'h01, 8'h00, 1'b1); expect_out("R7 rcr c1", 8'h80, 1, 0, 0, 1);
      apply(5'd15, 8'h02, 8'h00, 1'b0); expect_out("R7 rcr c0", 8'h01, 0, 0, 0, 1);
   endtask

   task automatic t_swap;
      apply(5'd16, 8'h3C, 8'h00, 1'b1); expect_out("R8 swap", 8'hC3, 1, 0, 0, 1);
      apply(5'd16, 8'h00, 8'h00, 1'b0); expect_out("R8 swap zero", 8'h00, 0, 1, 0, 1);
   endtask

   task automatic t_cmp;
      apply(5'd17, 8'h05, 8'h05, 1'b1); expect_out("R9 cmp equal", 8'h00, 0, 1, 0, 0);
      apply(5'd18, 8'h05, 8'h05, 1'b1); expect_out("R9 ceq equal skip", 8'h00, 0, 1, 1, 0);
      apply(5'd18, 8'h03, 8'h05, 1'b0); expect_out("R9 ceq unequal", 8'hFE, 1, 0, 0, 0);
   endtask

   task automatic t_incdec;
      apply(5'd19, 8'hFF, 8'h00, 1'b0); expect_out("R10 inc wrap no skip", 8'h00, 0, 1, 0, 1);
      apply(5'd20, 8'h00, 8'h00, 1'b1); expect_out("R10 dec wrap", 8'hFF, 1, 0, 0, 1);
      apply(5'd21, 8'hFF, 8'h00, 1'b0); expect_out("R10 incsz skip", 8'h00, 0, 1, 1, 1);
      apply(5'd21, 8'h10, 8'h00, 1'b1); expect_out("R10 incsz no skip", 8'h11, 1, 0, 0, 1);
      apply(5'd22, 8'h01, 8'h00, 1'b1); expect_out("R10 decsz skip", 8'h00, 1, 1, 1, 1);
      apply(5'd22, 8'h00, 8'h00, 1'b0); expect_out("R10 decsz no skip", 8'hFF, 0, 0, 0, 1);
   endtask

   task automatic t_mul;
      apply(5'd23, 8'hFF, 8'hFF, 1'b1); expect_out("R11 mul low", 8'h01, 1, 0, 0, 1);
      apply(5'd0, 8'h02, 8'h03, 1'b0); expect_out("R11 add after mul", 8'h05, 0, 0, 0, 1);
      chk("R11 mul_hi after edge", {24'd0, mul_hi_o}, 32'h0000_00FE);
      apply(5'd9, 8'h11, 8'h22, 1'b0);
      chk("R11 mul_hi holds", {24'd0, mul_hi_o}, 32'h0000_00FE);
      apply(5'd23, 8'h10, 8'h10, 1'b0); expect_out("R11 mul low zero R12", 8'h00, 0, 1, 0, 1);
      chk("R11 mul_hi before edge", {24'd0, mul_hi_o}, 32'h0000_00FE);
      apply(5'd31, 8'h00, 8'h00, 1'b0);
      chk("R11 mul_hi second product", {24'd0, mul_hi_o}, 32'h0000_0001);
   endtask

   task automatic t_undef;
      apply(5'd31, 8'h5A, 8'h33, 1'b1); expect_out("R13 undefined op", 8'h5A, 1, 0, 0, 0);
      apply(5'd24, 8'h00, 8'hFF, 1'b0); expect_out("R13 undefined op zero", 8'h00, 0, 1, 0, 0);
      chk("R13 mul_hi untouched", {24'd0, mul_hi_o}, 32'h0000_0001);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_add();
      t_sub();
      t_rsub();
      t_logic();
      t_neg();
      t_shift();
      t_rot();
      t_swap();
      t_cmp();
      t_incdec();
      t_mul();
      t_undef();
      finish_run();
   end

endmodule